// File: doc/BRIEF.md
# DMA Channel Enable Register with Transfer Progress

This block keeps the enable bits for a six-channel DMA engine. It also holds a small progress model for each channel: an element counter and a frame counter. The CPU writes the whole register at once, normally after reading it and OR-ing in a mask. Every enabled channel that sees a transfer request moves one element, and its counters step down. When the last element of the last frame has moved, the channel either drops its own enable bit (plain multiframe mode) or reloads its counters and keeps running (auto-reload mode, which covers both autoinitialization and auto-buffering).

The key property is how the block settles a CPU write that lands in the same cycle as a hardware completion. Each enable bit is resolved on its own. A written 1 only counts as a request when the bit was 0 beforehand. A 1 written over a bit that is already set means "leave it alone", so a completion clear in that cycle still takes effect. A read-modify-write that enables one channel therefore cannot restart another channel that has just finished. The bits above the enable field are plain configuration storage. Each channel's counters are brought out so that software can follow its progress.

Top module: `dma_chan_enable_reg`

## Requirements
- R1: After reset the register reads 0000h, every counter reads 0, and no transfer is granted even with all requests high.
- R2: Bit n (n = 0..5) enables channel n. A transfer is granted on channel n (xfer_go[n] = 1) in a cycle exactly when that bit reads 1 and xfer_req[n] is high.
- R3: Bits 15:6 take the written value on every CPU write and otherwise hold. Neither hardware completions nor transfers ever change them.
- R4: With configured counts E and F, a channel makes (E+1)*(F+1) grants per block. Each grant moves the element counter down by one. At element count 0 the counter reloads E and the frame counter moves down by one. blk_done[n] is high in the cycle of the grant made with both counts at 0.
- R5: In plain mode (cfg_auto[n] = 0), the completion clears enable bit n on the same clock edge, and both counters stay at 0.
- R6: In auto-reload mode (cfg_auto[n] = 1), the completion reloads E and F and enable bit n stays 1 until software writes it to 0.
- R7: A written 1 on an enable bit that reads 0 sets the bit and loads the channel's counters from cfg_elem/cfg_frame on the same edge.
- R8: A written 1 on an enable bit that already reads 1 changes neither the bit nor the counters. If a completion clear falls in the same cycle, the clear wins. For example, with 00C1h held, writing 00C3h as channel 0 (plain mode) completes leaves 00C2h.
- R9: A written 0 on an enable bit clears it on that edge. Its counters keep their values, and no further grants follow.
- R10: elem_cnt_o and frame_cnt_o show each channel's current counts in field n (bits n*8 +: 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU writes the register this cycle |
| cpu_wdata | input | 16 | Value written by the CPU |
| reg_rdata | output | 16 | Current register value |
| cfg_elem | input | 48 | Per-channel element count reload E, field n at n*8 |
| cfg_frame | input | 48 | Per-channel frame count reload F, field n at n*8 |
| cfg_auto | input | 6 | Per-channel auto-reload mode |
| xfer_req | input | 6 | Per-channel element transfer request |
| xfer_go | output | 6 | Per-channel transfer granted this cycle |
| blk_done | output | 6 | Per-channel block completed this cycle |
| elem_cnt_o | output | 48 | Per-channel current element count |
| frame_cnt_o | output | 48 | Per-channel current frame count |

## Verification
Two events can fall on the same enable bit in one cycle: a CPU register write and the hardware completion clear of a finishing channel. The bench sets up this collision directly. Channel 0 is configured for a single-element block and 00C1h is loaded. The bench then raises channel 0's request in the same cycle that 00C3h is written, and checks that the register reads 00C2h afterwards and that channel 0 gets no further grants. Random traffic with short blocks and frequent read-modify-write enables produces many more collisions. Every cycle is compared against a cycle-level reference model kept in the bench.

// File: rtl/dce_pkg.sv
package dce_pkg;

  // Outcome for one enable bit in one cycle
  typedef enum logic [1:0] {
    EN_HOLD   = 2'd0,
    EN_SET    = 2'd1,
    EN_CLR_SW = 2'd2,
    EN_CLR_HW = 2'd3
  } en_action_e;

  // Per-bit arbitration: an explicit software 0 always wins, a true 0->1
  // request sets, a redundant 1 is ignored so a completion clear survives.
  function automatic en_action_e resolve_enable(input logic cur,
                                                input logic wr,
                                                input logic wbit,
                                                input logic hw_clr);
    en_action_e act;
    if (wr && !wbit)             act = EN_CLR_SW;
    else if (wr && wbit && !cur) act = EN_SET;
    else if (hw_clr)             act = EN_CLR_HW;
    else                         act = EN_HOLD;
    return act;
  endfunction

  function automatic logic apply_action(input en_action_e act, input logic cur);
    logic nxt;
    case (act)
      EN_SET:  nxt = 1'b1;
      EN_HOLD: nxt = cur;
      default: nxt = 1'b0;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dce_enable_bit.sv
module dce_enable_bit
  import dce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  input  logic hw_clr,
  output logic en_q,
  output logic load,
  output logic collide
);

  en_action_e act;

  always_comb begin
    act     = resolve_enable(en_q, wr, wbit, hw_clr);
    load    = (act == EN_SET);
    collide = wr && wbit && en_q && hw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= apply_action(act, en_q);
  end

endmodule

// File: rtl/dce_chan_counter.sv
module dce_chan_counter #(
  parameter int ELEM_W  = 8,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               req,
  input  logic               load,
  input  logic               auto_mode,
  input  logic [ELEM_W-1:0]  cfg_elem,
  input  logic [FRAME_W-1:0] cfg_frame,
  output logic [ELEM_W-1:0]  elem_cnt,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic               go,
  output logic               done,
  output logic               hw_clr
);

  localparam logic [ELEM_W-1:0]  ELEM_ZERO  = '0;
  localparam logic [FRAME_W-1:0] FRAME_ZERO = '0;

  function automatic logic last_element(input logic [ELEM_W-1:0] e,
                                        input logic [FRAME_W-1:0] f);
    return (e == ELEM_ZERO) && (f == FRAME_ZERO);
  endfunction

  always_comb begin
    go     = en && req;
    done   = go && last_element(elem_cnt, frame_cnt);
    hw_clr = done && !auto_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_cnt  <= '0;
      frame_cnt <= '0;
    end else if (load || (done && auto_mode)) begin
      elem_cnt  <= cfg_elem;
      frame_cnt <= cfg_frame;
    end else if (go && !done) begin
      if (elem_cnt != ELEM_ZERO) begin
        elem_cnt <= elem_cnt - 1'b1;
      end else begin
        elem_cnt  <= cfg_elem;
        frame_cnt <= frame_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_chan_enable_reg.sv
module dma_chan_enable_reg #(
  parameter int NUM_CH  = 6,
  parameter int REG_W   = 16,
  parameter int ELEM_W  = 8,
  parameter int FRAME_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_wr,
  input  logic [REG_W-1:0]          cpu_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  input  logic [NUM_CH*ELEM_W-1:0]  cfg_elem,
  input  logic [NUM_CH*FRAME_W-1:0] cfg_frame,
  input  logic [NUM_CH-1:0]         cfg_auto,
  input  logic [NUM_CH-1:0]         xfer_req,
  output logic [NUM_CH-1:0]         xfer_go,
  output logic [NUM_CH-1:0]         blk_done,
  output logic [NUM_CH*ELEM_W-1:0]  elem_cnt_o,
  output logic [NUM_CH*FRAME_W-1:0] frame_cnt_o
);

  localparam int UP_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] hw_clr_vec;
  logic [NUM_CH-1:0] load_vec;
  logic [NUM_CH-1:0] collide_vec;
  logic [UP_W-1:0]   upper_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upper_q <= '0;
    else if (cpu_wr) upper_q <= cpu_wdata[REG_W-1:NUM_CH];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dce_enable_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cpu_wr),
      .wbit    (cpu_wdata[n]),
      .hw_clr  (hw_clr_vec[n]),
      .en_q    (en_vec[n]),
      .load    (load_vec[n]),
      .collide (collide_vec[n])
    );

    dce_chan_counter #(.ELEM_W(ELEM_W), .FRAME_W(FRAME_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_vec[n]),
      .req       (xfer_req[n]),
      .load      (load_vec[n]),
      .auto_mode (cfg_auto[n]),
      .cfg_elem  (cfg_elem[n*ELEM_W +: ELEM_W]),
      .cfg_frame (cfg_frame[n*FRAME_W +: FRAME_W]),
      .elem_cnt  (elem_cnt_o[n*ELEM_W +: ELEM_W]),
      .frame_cnt (frame_cnt_o[n*FRAME_W +: FRAME_W]),
      .go        (xfer_go[n]),
      .done      (blk_done[n]),
      .hw_clr    (hw_clr_vec[n])
    );
  end

  assign reg_rdata = {upper_q, en_vec};

endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int NUM_CH  = 6,
  parameter int REG_W   = 16,
  parameter int ELEM_W  = 8,
  parameter int FRAME_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cpu_wr,
  input logic [REG_W-1:0]          cpu_wdata,
  input logic [REG_W-1:0]          reg_rdata,
  input logic [NUM_CH*ELEM_W-1:0]  cfg_elem,
  input logic [NUM_CH*FRAME_W-1:0] cfg_frame,
  input logic [NUM_CH-1:0]         cfg_auto,
  input logic [NUM_CH-1:0]         xfer_go,
  input logic [NUM_CH-1:0]         blk_done,
  input logic [NUM_CH*ELEM_W-1:0]  elem_cnt_o,
  input logic [NUM_CH*FRAME_W-1:0] frame_cnt_o,
  input logic [NUM_CH-1:0]         collide_vec
);

  logic [NUM_CH-1:0] en;
  assign en = reg_rdata[NUM_CH-1:0];

  // R2
  done_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done & ~xfer_go) == '0);

  // R3
  upper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> reg_rdata[REG_W-1:NUM_CH] == $past(cpu_wdata[REG_W-1:NUM_CH]));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(reg_rdata[REG_W-1:NUM_CH]));

  // R5
  plain_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(blk_done & ~cfg_auto) |=> (en & $past(blk_done & ~cfg_auto)) == '0);

  // R6
  auto_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($past(en & cfg_auto) & ~en) == '0);

  // R8
  collision_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |collide_vec |=> (en & $past(collide_vec)) == '0);

  // R9
  sw_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (en & ~$past(cpu_wdata[NUM_CH-1:0])) == '0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R7
    rise_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en[n]) |->
        (elem_cnt_o[n*ELEM_W +: ELEM_W] == $past(cfg_elem[n*ELEM_W +: ELEM_W])) &&
        (frame_cnt_o[n*FRAME_W +: FRAME_W] == $past(cfg_frame[n*FRAME_W +: FRAME_W])));
  end

endmodule

bind dma_chan_enable_reg dce_checker #(
  .NUM_CH(NUM_CH), .REG_W(REG_W), .ELEM_W(ELEM_W), .FRAME_W(FRAME_W)
) i_dce_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_wr      (cpu_wr),
  .cpu_wdata   (cpu_wdata),
  .reg_rdata   (reg_rdata),
  .cfg_elem    (cfg_elem),
  .cfg_frame   (cfg_frame),
  .cfg_auto    (cfg_auto),
  .xfer_go     (xfer_go),
  .blk_done    (blk_done),
  .elem_cnt_o  (elem_cnt_o),
  .frame_cnt_o (frame_cnt_o),
  .collide_vec (collide_vec)
);

// File: tb/test_dma_chan_enable_reg.sv
`timescale 1ns/1ps
module test_dma_chan_enable_reg;

  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] reg_rdata;
  logic [47:0] cfg_elem = '0;
  logic [47:0] cfg_frame = '0;
  logic [5:0]  cfg_auto = '0;
  logic [5:0]  xfer_req = '0;
  logic [5:0]  xfer_go;
  logic [5:0]  blk_done;
  logic [47:0] elem_cnt_o;
  logic [47:0] frame_cnt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  bit [15:0] m_reg;
  int        m_e[NCH];
  int        m_f[NCH];

  always #5 clk = ~clk;

  dma_chan_enable_reg i_dma_chan_enable_reg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .reg_rdata(reg_rdata), .cfg_elem(cfg_elem), .cfg_frame(cfg_frame),
    .cfg_auto(cfg_auto), .xfer_req(xfer_req), .xfer_go(xfer_go),
    .blk_done(blk_done), .elem_cnt_o(elem_cnt_o), .frame_cnt_o(frame_cnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cfg_e(input int n);
    return int'(cfg_elem[n*8 +: 8]);
  endfunction

  function automatic int cfg_f(input int n);
    return int'(cfg_frame[n*8 +: 8]);
  endfunction

  // grants left in the block, counting the current one: drives done prediction
  function automatic int grants_left(input int n);
    return m_f[n] * (cfg_e(n) + 1) + m_e[n] + 1;
  endfunction

  task automatic model_eval(output bit [5:0] g, output bit [5:0] d);
    for (int n = 0; n < NCH; n++) begin
      g[n] = m_reg[n] && xfer_req[n];
      d[n] = g[n] && (grants_left(n) == 1);
    end
  endtask

  task automatic model_advance(input bit [5:0] g, input bit [5:0] d);
    bit [15:0] nr;
    nr = m_reg;
    if (cpu_wr) nr[15:6] = cpu_wdata[15:6];
    for (int n = 0; n < NCH; n++) begin
      bit rising;
      rising = cpu_wr && cpu_wdata[n] && !m_reg[n];
      if (cpu_wr && !cpu_wdata[n]) nr[n] = 1'b0;
      else if (rising)             nr[n] = 1'b1;
      else if (d[n] && !cfg_auto[n]) nr[n] = 1'b0;
      if (rising || (d[n] && cfg_auto[n])) begin
        m_e[n] = cfg_e(n);
        m_f[n] = cfg_f(n);
      end else if (g[n] && !d[n]) begin
        if (m_e[n] > 0) m_e[n]--;
        else begin
          m_e[n] = cfg_e(n);
          m_f[n]--;
        end
      end
    end
    m_reg = nr;
  endtask

  // Called at a falling edge with inputs set; leaves at the next falling edge.
  task automatic step(input string tag);
    bit [5:0] g, d;
    #1;
    model_eval(g, d);
    chk("R2 grant", {26'd0, xfer_go}, {26'd0, g});
    chk("R4 done", {26'd0, blk_done}, {26'd0, d});
    model_advance(g, d);
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
    xfer_req = '0;
    chk(tag, {16'd0, reg_rdata}, {16'd0, m_reg});
    for (int n = 0; n < NCH; n++)
      chk("R10 counts", {16'd0, elem_cnt_o[n*8 +: 8], frame_cnt_o[n*8 +: 8]},
          {16'd0, m_e[n][7:0], m_f[n][7:0]});
  endtask

  task automatic set_cfg(input int n, input int e, input int f, input bit au);
    cfg_elem[n*8 +: 8] = e[7:0];
    cfg_frame[n*8 +: 8] = f[7:0];
    cfg_auto[n] = au;
  endtask

  task automatic cpu_write(input bit [15:0] v, input string tag);
    cpu_wr = 1'b1;
    cpu_wdata = v;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ndone;
    int ngo;
    void'($urandom(32'h1F2E3D4C));
    m_reg = '0;
    for (int n = 0; n < NCH; n++) begin m_e[n] = 0; m_f[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, requests ignored
    xfer_req = 6'h3F;
    #1;
    chk("R1 rdata", {16'd0, reg_rdata}, 32'd0);
    chk("R1 grant", {26'd0, xfer_go}, 32'd0);
    chk("R1 counts", elem_cnt_o[31:0] | frame_cnt_o[31:0], 32'd0);
    step("R1");

    // R7: enabling channel 2 loads its counters
    set_cfg(2, 3, 1, 1'b0);
    cpu_write(16'h0004, "R7 rdata");
    chk("R7 elem", {24'd0, elem_cnt_o[23:16]}, 32'd3);
    chk("R7 frame", {24'd0, frame_cnt_o[23:16]}, 32'd1);

    // R4/R5: 8 grants, done on the last, then bit clears
    ndone = 0; ngo = 0;
    for (int k = 1; k <= 10; k++) begin
      xfer_req[2] = 1'b1;
      #1;
      if (xfer_go[2]) ngo++;
      if (blk_done[2]) ndone = k;
      step("R5");
    end
    chk("R4 grants", ngo, 32'd8);
    chk("R4 done cycle", ndone, 32'd8);
    chk("R5 bit cleared", {31'd0, reg_rdata[2]}, 32'd0);

    // R6: auto-reload channel 3 stays enabled, counters reload
    set_cfg(3, 1, 0, 1'b1);
    cpu_write(16'h0008, "R6");
    repeat (2) begin xfer_req[3] = 1'b1; step("R6"); end
    chk("R6 still enabled", {31'd0, reg_rdata[3]}, 32'd1);
    chk("R6 reloaded elem", {24'd0, elem_cnt_o[31:24]}, 32'd1);

    // R8: redundant 1 does not reload counters
    xfer_req[3] = 1'b1; step("R8");
    cpu_write(16'h0008, "R8 redundant");
    chk("R8 no reload", {24'd0, elem_cnt_o[31:24]}, 32'd0);

    // R9: write 0 clears, counters kept, no grants
    cpu_write(16'h0000, "R9");
    chk("R9 cleared", {31'd0, reg_rdata[3]}, 32'd0);
    chk("R9 counts kept", {24'd0, elem_cnt_o[31:24]}, 32'd0);
    xfer_req[3] = 1'b1;
    #1;
    chk("R9 no grant", {31'd0, xfer_go[3]}, 32'd0);
    step("R9");

    // R8: collision case 00C1h -> 00C3h while channel 0 completes
    set_cfg(0, 0, 0, 1'b0);
    set_cfg(1, 2, 0, 1'b0);
    cpu_write(16'h00C1, "R3 upper");
    xfer_req[0] = 1'b1;
    cpu_wr = 1'b1;
    cpu_wdata = 16'h00C3;
    step("R8 collision");
    chk("R8 collision value", {16'd0, reg_rdata}, 32'h00C2);
    xfer_req[0] = 1'b1;
    #1;
    chk("R8 no restart", {31'd0, xfer_go[0]}, 32'd0);
    step("R8");

    // Random traffic with read-modify-write enables
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 16) == 0) begin
        int n;
        n = $urandom % NCH;
        set_cfg(n, $urandom % 4, $urandom % 3, ($urandom % 4) == 0);
      end
      xfer_req = 6'($urandom);
      if (($urandom % 6) == 0) begin
        cpu_wr = 1'b1;
        case ($urandom % 3)
          0: cpu_wdata = reg_rdata | (16'h1 << ($urandom % NCH));
          1: cpu_wdata = reg_rdata & ~(16'h1 << ($urandom % NCH));
          default: cpu_wdata = 16'($urandom);
        endcase
      end
      step("R3 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule